// File: doc/BRIEF.md
# Extended 32-bit Integer ALU

This block is the integer execution unit of a small load/store processor. It receives two 32-bit operands and a 5-bit operation code, and it returns one 32-bit result. The operations are add and subtract, the low product word, the high product word in three signedness forms, signed quotient and remainder, six bitwise functions, logical and arithmetic shifts, rotates in both directions, and six compare-and-set tests.

The block is purely combinational. It has no clock, no state and no flag outputs. Decode, register-file access and the choice between a register operand and an immediate operand are done by the surrounding pipeline. An immediate reaches the block already sign-extended from 12 bits to 32 bits, so the value -2048 arrives as 0xFFFFF800. The pipeline registers the result at the stage boundary.

Top module: `ext_alu`

## Requirements
- R1: Code 0 returns (a + b) mod 2^32 and code 1 returns (a - b) mod 2^32.
- R2: Code 2 returns the low 32 bits of the product a * b.
- R3: Code 3 returns the upper 32 bits of the 64-bit product with both operands signed. Code 4 returns the upper 32 bits with both operands unsigned. Code 5 returns the upper 32 bits with a signed and b unsigned.
- R4: Code 6 returns the signed quotient a / b, truncated toward zero. Code 7 returns the signed remainder, which takes the sign of a.
- R5: When b is 0, code 6 returns 0xFFFFFFFF and code 7 returns a.
- R6: When a is 0x80000000 and b is 0xFFFFFFFF, code 6 returns 0x80000000 and code 7 returns 0.
- R7: The bitwise codes are 8 AND, 9 OR, 10 XOR, 11 NAND, 12 NOR and 13 XNOR.
- R8: The shift codes are 16 left logical, 17 right logical and 18 right arithmetic. Right arithmetic fills vacated bits with a[31]. The shift amount is b[4:0]. Bits b[31:5] are ignored.
- R9: Code 19 rotates a left by b[4:0] and code 20 rotates a right by b[4:0]. A rotate amount of 0 returns a.
- R10: The compare codes are 24 equal, 25 not-equal, 26 signed less-than, 27 signed greater-or-equal, 28 unsigned less-than and 29 unsigned greater-or-equal. Each returns 1 when the test is true and 0 when it is false.
- R11: Every code not listed above (14, 15, 21-23, 30 and 31) returns 0.
- R12: The result follows the inputs combinationally, so it is valid in the same cycle that the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, either a register value or a sign-extended immediate |
| result | output | 32 | Operation result |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and the result. The bench applies a new operand set and operation code just after each rising clock edge. It samples the result at the following falling edge, half a period later, and compares it there against a behavioural model. The model uses wide integer arithmetic and handles the two divide corner cases explicitly. Directed vectors cover the zero-divisor case, the overflow case, shift amounts above 31 and the unused codes. Pseudo-random vectors then sweep all 32 codes.

// File: rtl/ext_alu_pkg.sv
package ext_alu_pkg;
    typedef enum logic [4:0] {
        OP_ADD    = 5'd0,
        OP_SUB    = 5'd1,
        OP_MUL    = 5'd2,
        OP_MULH   = 5'd3,
        OP_MULHU  = 5'd4,
        OP_MULHSU = 5'd5,
        OP_DIV    = 5'd6,
        OP_REM    = 5'd7,
        OP_AND    = 5'd8,
        OP_OR     = 5'd9,
        OP_XOR    = 5'd10,
        OP_NAND   = 5'd11,
        OP_NOR    = 5'd12,
        OP_XNOR   = 5'd13,
        OP_SLL    = 5'd16,
        OP_SRL    = 5'd17,
        OP_SRA    = 5'd18,
        OP_ROL    = 5'd19,
        OP_ROR    = 5'd20,
        OP_SEQ    = 5'd24,
        OP_SNE    = 5'd25,
        OP_SLT    = 5'd26,
        OP_SGE    = 5'd27,
        OP_SLTU   = 5'd28,
        OP_SGEU   = 5'd29
    } alu_op_e;

    localparam int unsigned OP_W = 5;

    typedef struct packed {
        logic eq;
        logic lt_s;
        logic lt_u;
    } cmp_flags_t;
endpackage

// File: rtl/alu_mul_unit.sv
module alu_mul_unit #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0]   mul_a,
    input  logic [XLEN-1:0]   mul_b,
    input  logic              a_is_signed,
    input  logic              b_is_signed,
    output logic [2*XLEN-1:0] product
);
    localparam int unsigned PW = 2 * XLEN;

    logic [PW-1:0] a_ext_d;
    logic [PW-1:0] b_ext_d;

    always_comb begin
        // Extending both factors to the full product width gives the right
        // product modulo 2^PW for every signedness pairing.
        a_ext_d = {{XLEN{a_is_signed & mul_a[XLEN-1]}}, mul_a};
        b_ext_d = {{XLEN{b_is_signed & mul_b[XLEN-1]}}, mul_b};
        product = a_ext_d * b_ext_d;
    end
endmodule

// File: rtl/alu_div_unit.sv
module alu_div_unit #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] dvd,
    input  logic [XLEN-1:0] dvs,
    output logic [XLEN-1:0] quot,
    output logic [XLEN-1:0] remd
);
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] ALL_ONES = {XLEN{1'b1}};

    logic            sgn_a_d;
    logic            sgn_b_d;
    logic [XLEN-1:0] mag_a_d;
    logic [XLEN-1:0] mag_b_d;
    logic [XLEN:0]   part_d;
    logic [XLEN-1:0] q_mag_d;

    always_comb begin
        sgn_a_d = dvd[XLEN-1];
        sgn_b_d = dvs[XLEN-1];
        mag_a_d = sgn_a_d ? (~dvd + 1'b1) : dvd;
        mag_b_d = sgn_b_d ? (~dvs + 1'b1) : dvs;
        part_d  = '0;
        q_mag_d = '0;
        // Restoring division on magnitudes, one quotient bit per step.
        for (int i = XLEN - 1; i >= 0; i--) begin
            part_d = {part_d[XLEN-1:0], mag_a_d[i]};
            if (part_d >= {1'b0, mag_b_d}) begin
                part_d     = part_d - {1'b0, mag_b_d};
                q_mag_d[i] = 1'b1;
            end
        end
        if (dvs == '0) begin
            quot = ALL_ONES;
            remd = dvd;
        end else if (dvd == MOST_NEG && dvs == ALL_ONES) begin
            quot = dvd;
            remd = '0;
        end else begin
            quot = (sgn_a_d ^ sgn_b_d) ? (~q_mag_d + 1'b1) : q_mag_d;
            remd = sgn_a_d ? (~part_d[XLEN-1:0] + 1'b1) : part_d[XLEN-1:0];
        end
    end
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0]         sh_in,
    input  logic [$clog2(XLEN)-1:0] sh_amt,
    output logic [XLEN-1:0]         sll_o,
    output logic [XLEN-1:0]         srl_o,
    output logic [XLEN-1:0]         sra_o,
    output logic [XLEN-1:0]         rol_o,
    output logic [XLEN-1:0]         ror_o
);
    logic [2*XLEN-1:0] dbl_l_d;
    logic [2*XLEN-1:0] dbl_r_d;

    always_comb begin
        sll_o   = sh_in << sh_amt;
        srl_o   = sh_in >> sh_amt;
        sra_o   = $signed(sh_in) >>> sh_amt;
        // Shifting a doubled copy brings the wrapped bits in from the copy.
        dbl_l_d = {sh_in, sh_in} << sh_amt;
        dbl_r_d = {sh_in, sh_in} >> sh_amt;
        rol_o   = dbl_l_d[2*XLEN-1:XLEN];
        ror_o   = dbl_r_d[XLEN-1:0];
    end
endmodule

// File: rtl/ext_alu.sv
module ext_alu
    import ext_alu_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [4:0]      op_sel,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic [XLEN-1:0] result
);
    localparam int unsigned SHW = $clog2(XLEN);

    logic              mul_sa_d;
    logic              mul_sb_d;
    logic [2*XLEN-1:0] prod_w;
    logic [XLEN-1:0]   quot_w;
    logic [XLEN-1:0]   remd_w;
    logic [XLEN-1:0]   sll_w, srl_w, sra_w, rol_w, ror_w;
    cmp_flags_t        cmp_d;
    logic [XLEN-1:0]   result_d;

    always_comb begin
        mul_sa_d = (op_sel == OP_MULH) || (op_sel == OP_MULHSU);
        mul_sb_d = (op_sel == OP_MULH);
    end

    alu_mul_unit #(.XLEN(XLEN)) u_mul (
        .mul_a       (opnd_a),
        .mul_b       (opnd_b),
        .a_is_signed (mul_sa_d),
        .b_is_signed (mul_sb_d),
        .product     (prod_w)
    );

    alu_div_unit #(.XLEN(XLEN)) u_div (
        .dvd  (opnd_a),
        .dvs  (opnd_b),
        .quot (quot_w),
        .remd (remd_w)
    );

    alu_shift_unit #(.XLEN(XLEN)) u_shift (
        .sh_in  (opnd_a),
        .sh_amt (opnd_b[SHW-1:0]),
        .sll_o  (sll_w),
        .srl_o  (srl_w),
        .sra_o  (sra_w),
        .rol_o  (rol_w),
        .ror_o  (ror_w)
    );

    always_comb begin
        cmp_d.eq   = (opnd_a == opnd_b);
        cmp_d.lt_s = ($signed(opnd_a) < $signed(opnd_b));
        cmp_d.lt_u = (opnd_a < opnd_b);
    end

    always_comb begin
        result_d = '0;
        case (op_sel)
            OP_ADD:    result_d = opnd_a + opnd_b;
            OP_SUB:    result_d = opnd_a - opnd_b;
            OP_MUL:    result_d = prod_w[XLEN-1:0];
            OP_MULH,
            OP_MULHU,
            OP_MULHSU: result_d = prod_w[2*XLEN-1:XLEN];
            OP_DIV:    result_d = quot_w;
            OP_REM:    result_d = remd_w;
            OP_AND:    result_d = opnd_a & opnd_b;
            OP_OR:     result_d = opnd_a | opnd_b;
            OP_XOR:    result_d = opnd_a ^ opnd_b;
            OP_NAND:   result_d = ~(opnd_a & opnd_b);
            OP_NOR:    result_d = ~(opnd_a | opnd_b);
            OP_XNOR:   result_d = ~(opnd_a ^ opnd_b);
            OP_SLL:    result_d = sll_w;
            OP_SRL:    result_d = srl_w;
            OP_SRA:    result_d = sra_w;
            OP_ROL:    result_d = rol_w;
            OP_ROR:    result_d = ror_w;
            OP_SEQ:    result_d = {{(XLEN-1){1'b0}}, cmp_d.eq};
            OP_SNE:    result_d = {{(XLEN-1){1'b0}}, ~cmp_d.eq};
            OP_SLT:    result_d = {{(XLEN-1){1'b0}}, cmp_d.lt_s};
            OP_SGE:    result_d = {{(XLEN-1){1'b0}}, ~cmp_d.lt_s};
            OP_SLTU:   result_d = {{(XLEN-1){1'b0}}, cmp_d.lt_u};
            OP_SGEU:   result_d = {{(XLEN-1){1'b0}}, ~cmp_d.lt_u};
            default:   result_d = '0;
        endcase
    end

    assign result = result_d;
endmodule

// File: rtl/ext_alu_chk.sv
module ext_alu_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic [4:0]      op_sel,
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] opnd_b,
    input logic [XLEN-1:0] result
);
    always_comb begin
        if (!$isunknown({op_sel, opnd_a, opnd_b, result})) begin
            if (op_sel == 5'd1) begin
                p_sub_inverse_r1: assert (result + opnd_b == opnd_a)
                    else $error("sub result plus b differs from a");
            end
            if (op_sel == 5'd6 && opnd_b == '0) begin
                p_div_zero_quot_r5: assert (result == {XLEN{1'b1}})
                    else $error("quotient for zero divisor not all ones");
            end
            if (op_sel == 5'd7 && opnd_b == '0) begin
                p_div_zero_rem_r5: assert (result == opnd_a)
                    else $error("remainder for zero divisor not the dividend");
            end
            if (op_sel == 5'd6 && opnd_a == {1'b1, {(XLEN-1){1'b0}}} && opnd_b == {XLEN{1'b1}}) begin
                p_no_overflow_r6: assert (result == opnd_a)
                    else $error("overflow quotient not the dividend");
            end
            if ((op_sel == 5'd19 || op_sel == 5'd20) && opnd_b[4:0] == 5'd0) begin
                p_rot_zero_r9: assert (result == opnd_a)
                    else $error("zero rotate changed the operand");
            end
            if (op_sel >= 5'd24 && op_sel <= 5'd29) begin
                p_cmp_bool_r10: assert (result[XLEN-1:1] == '0)
                    else $error("compare result wider than one bit");
            end
            if (op_sel == 5'd14 || op_sel == 5'd15 || (op_sel >= 5'd21 && op_sel <= 5'd23)
                || op_sel >= 5'd30) begin
                p_unused_zero_r11: assert (result == '0)
                    else $error("unused code returned nonzero");
            end
        end
    end
endmodule

bind ext_alu ext_alu_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/ext_alu_tb.sv
`timescale 1ns/1ps
module ext_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_sel = 5'd31;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic [31:0] exp_q = '0;
    string       tag_q = "R11";
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ext_alu u_dut (.op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result));

    function automatic string req_of(input logic [4:0] op, input logic [31:0] b);
        if (op <= 5'd1) return "R1";
        if (op == 5'd2) return "R2";
        if (op <= 5'd5) return "R3";
        if (op <= 5'd7) return (b == 0) ? "R5" : "R4";
        if (op <= 5'd13) return "R7";
        if (op >= 5'd16 && op <= 5'd18) return "R8";
        if (op == 5'd19 || op == 5'd20) return "R9";
        if (op >= 5'd24 && op <= 5'd29) return "R10";
        return "R11";
    endfunction

    function automatic logic [31:0] model(input logic [4:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        longint          sa, sb;
        longint unsigned ua, ub, pr;
        int              ia, ib, n;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ua = {32'b0, a};
        ub = {32'b0, b};
        ia = $signed(a);
        ib = $signed(b);
        n  = int'(b[4:0]);
        case (op)
            5'd0: return a + b;
            5'd1: return a - b;
            5'd2: begin pr = ua * ub; return pr[31:0]; end
            5'd3: begin pr = longint'(sa * sb); return pr[63:32]; end
            5'd4: begin pr = ua * ub; return pr[63:32]; end
            5'd5: begin pr = longint'(sa * longint'(ub)); return pr[63:32]; end
            5'd6: begin
                if (b == 0) return 32'hFFFF_FFFF;
                if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return a;
                return ia / ib;
            end
            5'd7: begin
                if (b == 0) return a;
                if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 0;
                return ia % ib;
            end
            5'd8:  return a & b;
            5'd9:  return a | b;
            5'd10: return a ^ b;
            5'd11: return ~(a & b);
            5'd12: return ~(a | b);
            5'd13: return ~(a ^ b);
            5'd16: return a << n;
            5'd17: return a >> n;
            5'd18: return 32'(sa >>> n);
            5'd19: return (n == 0) ? a : ((a << n) | (a >> (32 - n)));
            5'd20: return (n == 0) ? a : ((a >> n) | (a << (32 - n)));
            5'd24: return {31'b0, a == b};
            5'd25: return {31'b0, a != b};
            5'd26: return {31'b0, ia < ib};
            5'd27: return {31'b0, ia >= ib};
            5'd28: return {31'b0, a < b};
            5'd29: return {31'b0, a >= b};
            default: return 0;
        endcase
    endfunction

    // Result is combinational (R12): inputs applied after a rising edge are
    // compared at the falling edge of the same cycle.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (result !== exp_q) begin
                errors++;
                $display("FAIL %s R12 op=%0d a=%h b=%h actual=%h expected=%h",
                         tag_q, op_sel, opnd_a, opnd_b, result, exp_q);
            end
        end
    end

    task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        #0.5;
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        exp_q  = model(op, a, b);
        tag_q  = req_of(op, b);
    endtask

    initial begin
        exp_q = 0;  // reset state: unused code 31 gives 0 (R11)
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1
        apply(5'd0, 32'hFFFF_FFFF, 32'h0000_0002);
        apply(5'd1, 32'h0000_0000, 32'h0000_0001);
        apply(5'd0, 32'h0000_1234, 32'hFFFF_F800);   // sign-extended -2048
        // R2, R3
        apply(5'd2, 32'h8000_0001, 32'h0000_0003);
        apply(5'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply(5'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply(5'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply(5'd3, 32'h8000_0000, 32'h8000_0000);
        // R4
        apply(5'd6, 32'hFFFF_FFF9, 32'h0000_0002);
        apply(5'd7, 32'hFFFF_FFF9, 32'h0000_0002);
        apply(5'd6, 32'h0000_0007, 32'hFFFF_FFFE);
        apply(5'd7, 32'h0000_0007, 32'hFFFF_FFFE);
        // R5
        apply(5'd6, 32'h1234_5678, 32'h0);
        apply(5'd7, 32'hDEAD_BEEF, 32'h0);
        // R6
        apply(5'd6, 32'h8000_0000, 32'hFFFF_FFFF);
        apply(5'd7, 32'h8000_0000, 32'hFFFF_FFFF);
        // R7
        for (int k = 8; k <= 13; k++) apply(5'(k), 32'hF0F0_1234, 32'h0FF0_FF00);
        // R8: upper bits of b ignored
        apply(5'd16, 32'h0000_0001, 32'hFFFF_FFE4);
        apply(5'd17, 32'h8000_0000, 32'h0000_0020);
        apply(5'd18, 32'h8000_0000, 32'h0000_001F);
        // R9
        apply(5'd19, 32'h8000_0001, 32'h0000_0001);
        apply(5'd20, 32'h8000_0001, 32'h0000_0001);
        apply(5'd19, 32'hA5A5_0F0F, 32'h0000_0040);
        // R10
        for (int k = 24; k <= 29; k++) begin
            apply(5'(k), 32'hFFFF_FFFF, 32'h0000_0001);
            apply(5'(k), 32'h0000_0005, 32'h0000_0005);
        end
        // R11
        foreach (opnd_a[i]) begin end
        apply(5'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply(5'd15, 32'hFFFF_FFFF, 32'h1);
        apply(5'd21, 32'h1, 32'h1);
        apply(5'd22, 32'h1, 32'h1);
        apply(5'd23, 32'h1, 32'h1);
        apply(5'd30, 32'h1, 32'h1);
        // random sweep over all codes
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            case (k % 5)
                1: rb = 32'(rb[4:0]);
                2: rb = 0;
                3: rb = 32'hFFFF_FFFF;
                default: ;
            endcase
            apply(5'(k % 32), ra, rb);
        end
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R12 actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule